// File: doc/BRIEF.md
# Fixed-Point Decode and Register Execute Stage

This block accepts one 32-bit instruction word per cycle and decodes a small integer subset. Two operations execute here: add-immediate and register bitwise OR. The block holds a 32 x 64-bit general register file. The file has two combinational read ports and one write port that commits on the clock edge. The block drives the write-back value, the target index and the write strobe as outputs. It also sorts three other instruction shapes into branch, load and store classes, so that a sequencer can hand them to other units. Any other word raises an illegal-instruction flag.

Instruction bits use big-endian numbering: bit 0 is the most significant bit, which is `instr_i[31]`. In general, instruction bit k sits at `instr_i[31-k]`. The primary opcode is bits 0..5. Execution happens only in a cycle where `valid_i` is high.

Top module: `fxd_core`

## Requirements
- R1: Add-immediate (primary opcode 001110) writes register RT (bits 6..10) with GPR[RA] + sext(SI). RA is bits 11..15 and SI is the signed immediate in bits 16..31.
- R2: When the RA field of add-immediate is 0, the base is literal zero and the register 0 contents are not used. Register 0 is otherwise an ordinary register.
- R3: SI is sign-extended from 16 to 64 bits, and the sum wraps modulo 2^64.
- R4: OR needs primary opcode 011111 and extended opcode bits 21..30 = 0110111100. It writes register A (bits 11..15) with GPR[S] | GPR[B], where S is bits 6..10 and B is bits 16..20.
- R5: Bit 31 of OR (the record bit) does not change the result or the write.
- R6: A word that matches no supported pattern raises `illegal_o`, drives `class_o` = 0 and writes no register.
- R7: `class_o` is 1 (branch) for primary 010011 with extended bits 21..30 = 0000010000. It is 2 (load) for primary 100000. It is 3 (store) for primary 100100 or 100101. These words are legal and write no register. ALU and illegal words give 0.
- R8: Register reads are combinational. A write commits on the rising edge only when `valid_i` is high, and it is visible in the next cycle. With `valid_i` low, nothing is written.
- R9: Reset clears every register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Instruction present this cycle |
| instr_i | input | 32 | Instruction word, bit 0 = MSB |
| illegal_o | output | 1 | Word not recognised |
| class_o | output | 2 | 0 ALU/none, 1 branch, 2 load, 3 store |
| wb_en_o | output | 1 | Register write this edge |
| wb_addr_o | output | 5 | Write target index |
| wb_data_o | output | 64 | Write-back value |

## Verification
The assertions assume that `valid_i` and `instr_i` are stable for a whole cycle. They also assume that reset is held for at least one edge before release. The bench drives inputs only on the falling edge and releases reset after several cycles, so both assumptions hold. The register contents are observed only through the normal path: an OR of a register with itself returns that register on `wb_data_o`. The checks of discarded writes, the zero base and reset use this readback.

// File: rtl/fxd_core.sv
module fxd_core #(
  parameter int XLEN = 64,
  parameter int NREG = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            valid_i,
  input  logic [31:0]     instr_i,
  output logic            illegal_o,
  output logic [1:0]      class_o,
  output logic            wb_en_o,
  output logic [4:0]      wb_addr_o,
  output logic [XLEN-1:0] wb_data_o
);
  localparam logic [5:0] OP_ADDI = 6'b001110;
  localparam logic [5:0] OP_XO31 = 6'b011111;
  localparam logic [5:0] OP_XL19 = 6'b010011;
  localparam logic [5:0] OP_LDW  = 6'b100000;
  localparam logic [5:0] OP_STW  = 6'b100100;
  localparam logic [5:0] OP_STWU = 6'b100101;
  localparam logic [9:0] XO_OR   = 10'b0110111100;
  localparam logic [9:0] XO_BRLR = 10'b0000010000;
  localparam logic [1:0] CLS_NONE = 2'd0, CLS_BR = 2'd1, CLS_LD = 2'd2, CLS_ST = 2'd3;

  logic [XLEN-1:0] gpr [NREG];

  logic [5:0] opc;
  logic [4:0] f_t, f_a, f_b;
  logic [9:0] xo;
  logic [15:0] imm;
  assign opc = instr_i[31:26];
  assign f_t = instr_i[25:21];
  assign f_a = instr_i[20:16];
  assign f_b = instr_i[15:11];
  assign xo  = instr_i[10:1];
  assign imm = instr_i[15:0];

  logic is_addi, is_or, is_br, is_ld, is_st;
  assign is_addi = opc == OP_ADDI;
  assign is_or   = opc == OP_XO31 && xo == XO_OR;
  assign is_br   = opc == OP_XL19 && xo == XO_BRLR;
  assign is_ld   = opc == OP_LDW;
  assign is_st   = opc == OP_STW || opc == OP_STWU;

  assign illegal_o = !(is_addi || is_or || is_br || is_ld || is_st);
  assign class_o   = is_br ? CLS_BR : is_ld ? CLS_LD : is_st ? CLS_ST : CLS_NONE;

  logic [XLEN-1:0] rd_p0, rd_p1, base, sext_imm;
  assign rd_p0    = gpr[is_or ? f_t : f_a];
  assign rd_p1    = gpr[f_b];
  assign base     = (f_a == 5'd0) ? '0 : rd_p0;
  assign sext_imm = {{(XLEN-16){imm[15]}}, imm};

  assign wb_data_o = is_or ? (rd_p0 | rd_p1) : (base + sext_imm);
  assign wb_addr_o = is_or ? f_a : f_t;
  assign wb_en_o   = valid_i && (is_addi || is_or);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) gpr[i] <= '0;
    end else if (wb_en_o) begin
      gpr[wb_addr_o] <= wb_data_o;
    end
  end

  a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(wb_en_o) |-> gpr[$past(wb_addr_o)] == $past(wb_data_o));

  a_r6_illegal_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && illegal_o |=> gpr[$past(f_a)] == $past(gpr[f_a]));

  a_r6_illegal_class: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> class_o == CLS_NONE && !wb_en_o);

  a_r7_dispatch_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    class_o != CLS_NONE |-> !wb_en_o && !illegal_o);

  a_r2_zero_base: assert property (@(posedge clk) disable iff (!rst_n)
    opc == OP_ADDI && f_a == 5'd0 |-> wb_data_o == {{(XLEN-16){instr_i[15]}}, instr_i[15:0]});

  a_r9_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> gpr[1] == '0 && gpr[NREG-1] == '0);
endmodule

// File: tb/fxd_core_tb_top.sv
module fxd_core_tb_top;
  logic clk = 0, rst_n = 0, valid_i = 0;
  logic [31:0] instr_i = '0;
  logic illegal_o, wb_en_o;
  logic [1:0] class_o;
  logic [4:0] wb_addr_o;
  logic [63:0] wb_data_o;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  fxd_core dut_i (.clk(clk), .rst_n(rst_n), .valid_i(valid_i), .instr_i(instr_i),
    .illegal_o(illegal_o), .class_o(class_o), .wb_en_o(wb_en_o),
    .wb_addr_o(wb_addr_o), .wb_data_o(wb_data_o));

  function automatic logic [31:0] enc_addi(input int t, input int a, input logic [15:0] si);
    return {6'b001110, 5'(t), 5'(a), si};
  endfunction
  function automatic logic [31:0] enc_or(input int a, input int s, input int b, input bit rc);
    return {6'b011111, 5'(s), 5'(a), 5'(b), 10'b0110111100, rc};
  endfunction

  // row: instr[99:68] data[67:4] illegal[3] class[2:1] wen[0]
  localparam int NV = 14;
  localparam logic [99:0] VEC [NV] = '{
    {enc_addi(1, 0, 16'd5),      64'd5,               1'b0, 2'd0, 1'b1}, // R1 R2
    {enc_addi(2, 1, 16'hFFFD),   64'd2,               1'b0, 2'd0, 1'b1}, // R1 R3
    {enc_addi(3, 0, 16'hFFFF),   {64{1'b1}},          1'b0, 2'd0, 1'b1}, // R3
    {enc_addi(4, 3, 16'd1),      64'd0,               1'b0, 2'd0, 1'b1}, // R3 wrap
    {enc_or(5, 1, 2, 1'b0),      64'd7,               1'b0, 2'd0, 1'b1}, // R4
    {enc_or(6, 3, 1, 1'b1),      {64{1'b1}},          1'b0, 2'd0, 1'b1}, // R5
    {enc_or(1, 3, 3, 1'b0) ^ 32'h2, 64'd0,            1'b1, 2'd0, 1'b0}, // R6 bad xo
    {32'h8020_0000,              64'd0,               1'b0, 2'd2, 1'b0}, // R7 load
    {32'h9020_0000,              64'd0,               1'b0, 2'd3, 1'b0}, // R7 store
    {32'h9420_0000,              64'd0,               1'b0, 2'd3, 1'b0}, // R7 store-update
    {32'h4E80_0020,              64'd0,               1'b0, 2'd1, 1'b0}, // R7 branch
    {32'h4E80_0022,              64'd0,               1'b1, 2'd0, 1'b0}, // R6 branch bad xo
    {enc_or(7, 1, 1, 1'b0),      64'd5,               1'b0, 2'd0, 1'b1}, // R6 r1 kept
    {enc_or(8, 4, 4, 1'b0),      64'd0,               1'b0, 2'd0, 1'b1}  // R3 wrap stored
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [31:0] w);
    @(negedge clk);
    valid_i = v; instr_i = w;
    #1;
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    step(0, enc_or(9, 5, 5, 1'b0));
    chk("R9 reset reg5", wb_data_o, 64'd0);
    step(0, 32'h0);
    chk("R6 zero word illegal", {63'd0, illegal_o}, 64'd1);

    for (int i = 0; i < NV; i++) begin
      step(1, VEC[i][99:68]);
      chk($sformatf("R6 illegal row%0d", i), {63'd0, illegal_o}, {63'd0, VEC[i][3]});
      chk($sformatf("R7 class row%0d", i), {62'd0, class_o}, {62'd0, VEC[i][2:1]});
      chk($sformatf("R8 wen row%0d", i), {63'd0, wb_en_o}, {63'd0, VEC[i][0]});
      if (VEC[i][0]) chk($sformatf("R1 R4 data row%0d", i), wb_data_o, VEC[i][67:4]);
    end

    // R8: no write without valid
    step(0, enc_addi(9, 0, 16'd77));
    chk("R8 data offered", wb_data_o, 64'd77);
    step(1, enc_or(10, 9, 9, 1'b0));
    chk("R8 no write when invalid", wb_data_o, 64'd0);

    // R2: r0 holds 9 but addi base 0 stays literal zero
    step(1, enc_addi(0, 0, 16'd9));
    step(1, enc_or(11, 0, 0, 1'b0));
    chk("R2 r0 is a real register", wb_data_o, 64'd9);
    step(1, enc_addi(12, 0, 16'd1));
    chk("R2 zero base", wb_data_o, 64'd1);
    step(1, enc_addi(12, 12, 16'h8000));
    chk("R3 most negative imm", wb_data_o, 64'hFFFF_FFFF_FFFF_8001);

    // R9: reset clears again
    @(negedge clk) begin valid_i = 0; rst_n = 0; end
    @(negedge clk) rst_n = 1;
    step(0, enc_or(13, 1, 1, 1'b0));
    chk("R9 reset reg1", wb_data_o, 64'd0);
    step(0, enc_or(13, 0, 0, 1'b0));
    chk("R9 reset reg0", wb_data_o, 64'd0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule